// File: doc/BRIEF.md
# Dual-Channel Framed Serial Sample Receiver

This block takes two 10-bit sample words, one for the in-phase channel and one for the quadrature channel, arriving at the same time on two separate serial data lines. A frame strobe marks the start of each word. The frame strobe and both data lines are sampled on the rising edge of the master clock. Once the last bit of a word has arrived, both words are moved together into output registers and a one-cycle update strobe goes out to the DAC update path. A frame normally lasts 16 clocks, giving one update per frame. Only the first ten clocks of a frame carry data.

A two-bit operating-mode input is decoded into four exclusive flags. The flags tell the rest of the chip whether the modulator path or this direct sample path drives the converters. Words are delivered in every mode except the reserved code. In the reserved code the outputs keep their last value and no strobe is sent.

Top module: `dfr_top`

## Requirements
- R1: While rst_ni is low and after it is released, i_word_o and q_word_o are zero and update_o is low until the first complete word.
- R2: The clock edge at which frame_i is sampled high captures bit 9 (MSB) of both words. The next 9 rising edges capture bits 8 down to 0, in order, on both lines in parallel.
- R3: When bit 0 is captured, both output words take their new values together, and update_o goes high for exactly one cycle in the clock period that follows that edge.
- R4: Data-line activity after bit 0 and before the next frame_i high sample produces no update_o and leaves both output words unchanged.
- R5: frame_i sampled high before bit 0 of the current word discards the partial word and restarts reception with that edge as bit 9. Only the restarted word is delivered.
- R6: mode_i decodes, with mode_i[0] as the first mode pin and mode_i[1] as the second: 2'b00 raises mode_mod_o, 2'b01 raises mode_direct_o, 2'b10 raises mode_test_o, and 2'b11 raises mode_rsvd_o. Exactly one flag is high at any time.
- R7: If mode_i is 2'b11 at the edge that captures bit 0, no update_o is issued and both output words hold their previous values.
- R8: Back-to-back 16-clock frames each produce exactly one update carrying that frame's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame strobe, high marks bit 9 |
| i_data_i | input | 1 | In-phase serial data, MSB first |
| q_data_i | input | 1 | Quadrature serial data, MSB first |
| mode_i | input | 2 | Operating-mode code |
| i_word_o | output | 10 | Latched in-phase word |
| q_word_o | output | 10 | Latched quadrature word |
| update_o | output | 1 | One-cycle update strobe |
| mode_mod_o | output | 1 | Digital modulator mode selected |
| mode_direct_o | output | 1 | Direct sample mode selected |
| mode_test_o | output | 1 | Test mode selected |
| mode_rsvd_o | output | 1 | Reserved code present |

## Verification
The bench uses words with asymmetric bit patterns. A design that reversed the bit order, lost the bit taken on the frame edge, or swapped the lanes would therefore deliver a wrong value. It restarts a word part-way and again right at the bit-0 position. A design that kept stale bits would emit a corrupted word or an extra strobe. It also toggles the data lines in the idle part of each frame, to expose a receiver that keeps shifting after bit 0. It sends a whole frame under the reserved code, where a design that ignored the mode would strobe and overwrite the held words.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    MODE_MOD    = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_TEST   = 2'b10,
    MODE_RSVD   = 2'b11
  } op_mode_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/dfr_mode_dec.sv
module dfr_mode_dec
  import dfr_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic       mod_o,
  output logic       direct_o,
  output logic       test_o,
  output logic       rsvd_o
);
  op_mode_e mode;
  assign mode = op_mode_e'(mode_i);

  always_comb begin
    mod_o    = 1'b0;
    direct_o = 1'b0;
    test_o   = 1'b0;
    rsvd_o   = 1'b0;
    case (mode)
      MODE_MOD:    mod_o    = 1'b1;
      MODE_DIRECT: direct_o = 1'b1;
      MODE_TEST:   test_o   = 1'b1;
      default:     rsvd_o   = 1'b1;
    endcase
  end
endmodule

// File: rtl/dfr_frame_ctrl.sv
module dfr_frame_ctrl #(
  parameter int unsigned WORD_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic load_o,
  output logic shift_o,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o  = frame_i;
  assign shift_o = !frame_i && active_q;
  assign last_o  = shift_o && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (frame_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(1);
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  restart_no_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> !last_o);
endmodule

// File: rtl/dfr_lane.sv
module dfr_lane #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              commit_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
    end else if (load_i) begin
      sreg_q <= {{(WORD_W-1){1'b0}}, bit_i};
    end else if (shift_i) begin
      sreg_q <= {sreg_q[WORD_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else if (commit_i) word_o <= {sreg_q[WORD_W-2:0], bit_i};
  end
endmodule

// File: rtl/dfr_top.sv
module dfr_top
  import dfr_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              i_data_i,
  input  logic              q_data_i,
  input  logic [1:0]        mode_i,
  output logic [WORD_W-1:0] i_word_o,
  output logic [WORD_W-1:0] q_word_o,
  output logic              update_o,
  output logic              mode_mod_o,
  output logic              mode_direct_o,
  output logic              mode_test_o,
  output logic              mode_rsvd_o
);
  logic load, shift, last, commit;
  logic [NUM_LANES-1:0]             lane_bit;
  logic [NUM_LANES-1:0][WORD_W-1:0] lane_word;

  dfr_mode_dec u_mode_dec (
    .mode_i   (mode_i),
    .mod_o    (mode_mod_o),
    .direct_o (mode_direct_o),
    .test_o   (mode_test_o),
    .rsvd_o   (mode_rsvd_o)
  );

  dfr_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .load_o  (load),
    .shift_o (shift),
    .last_o  (last)
  );

  // reserved code blocks delivery
  assign commit   = last && !mode_rsvd_o;
  assign lane_bit = {q_data_i, i_data_i};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dfr_lane #(.WORD_W(WORD_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .shift_i  (shift),
      .commit_i (commit),
      .bit_i    (lane_bit[g]),
      .word_o   (lane_word[g])
    );
  end

  assign i_word_o = lane_word[0];
  assign q_word_o = lane_word[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) update_o <= 1'b0;
    else         update_o <= commit;
  end

  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);
  // R4
  hold_words_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> ($stable(i_word_o) && $stable(q_word_o)));
  // R7
  rsvd_no_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> ($past(mode_i) != 2'b11));
  // R6
  mode_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mode_mod_o, mode_direct_o, mode_test_o, mode_rsvd_o}) == 1);
endmodule

// File: tb/dfr_top_tb.sv
module dfr_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame = 1'b0, id = 1'b0, qd = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [9:0] i_w, q_w;
  logic upd, f_mod, f_dir, f_tst, f_rsv;

  int checks = 0, fails = 0, upd_cnt = 0;
  bit done = 1'b0;
  logic [19:0] exp_q[$];
  logic prev_upd = 1'b0;

  always #5 clk = ~clk;

  dfr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .i_data_i(id), .q_data_i(qd),
    .mode_i(mode), .i_word_o(i_w), .q_word_o(q_w), .update_o(upd),
    .mode_mod_o(f_mod), .mode_direct_o(f_dir), .mode_test_o(f_tst), .mode_rsvd_o(f_rsv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (upd) begin
        upd_cnt++;
        chk(!prev_upd, "R3 strobe width", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected update", {q_w, i_w}, 0);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          chk({q_w, i_w} == e, "R2 word value", {q_w, i_w}, e);
        end
      end
      prev_upd = upd;
    end
  end

  task automatic drive_bit(input logic f, input logic i, input logic q);
    @(negedge clk);
    frame = f; id = i; qd = q;
  endtask

  task automatic send_bits(input logic [9:0] i, input logic [9:0] q, input int n);
    for (int b = 9; b > 9 - n; b--) drive_bit(b == 9, i[b], q[b]);
  endtask

  task automatic pad(input int n);
    for (int k = 0; k < n; k++) drive_bit(1'b0, 1'($urandom), 1'($urandom));
  endtask

  task automatic send_frame(input logic [9:0] i, input logic [9:0] q);
    if (mode != 2'b11) exp_q.push_back({q, i});
    send_bits(i, q, 10);
    pad(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    // R1 reset state
    id = 1'b1; qd = 1'b1; frame = 1'b1;
    repeat (3) @(negedge clk);
    chk(i_w == 0 && q_w == 0 && !upd, "R1 in reset", {q_w, i_w, upd}, 0);
    frame = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(i_w == 0 && q_w == 0 && !upd, "R1 after reset", {q_w, i_w, upd}, 0);

    // R6 decode
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      #1;
      chk({f_rsv, f_tst, f_dir, f_mod} == 4'(1 << m), "R6 mode flags",
          {f_rsv, f_tst, f_dir, f_mod}, 1 << m);
    end
    mode = 2'b01;

    // R2 R8 back-to-back frames
    base = upd_cnt;
    send_frame(10'h3FF, 10'h000);
    send_frame(10'h2C5, 10'h13A);
    send_frame(10'h001, 10'h200);
    chk(upd_cnt - base == 3, "R8 one update per frame", upd_cnt - base, 3);

    // R4 idle noise keeps words
    base = upd_cnt;
    pad(20);
    chk(i_w == 10'h001 && q_w == 10'h200, "R4 words held", {q_w, i_w}, 20'h80001);
    chk(upd_cnt == base, "R4 no strobe in idle", upd_cnt - base, 0);

    // R5 restart mid-word and at bit-0 slot
    base = upd_cnt;
    send_bits(10'h3FF, 10'h3FF, 5);
    send_frame(10'h0F0, 10'h30F);
    send_bits(10'h155, 10'h2AA, 9);
    send_frame(10'h1E3, 10'h05C);
    chk(upd_cnt - base == 2, "R5 partial words dropped", upd_cnt - base, 2);
    chk(i_w == 10'h1E3 && q_w == 10'h05C, "R5 restarted word", {q_w, i_w}, {10'h05C, 10'h1E3});

    // R7 reserved mode
    base = upd_cnt;
    mode = 2'b11;
    send_frame(10'h111, 10'h222);
    chk(upd_cnt == base, "R7 no strobe in reserved", upd_cnt - base, 0);
    chk(i_w == 10'h1E3 && q_w == 10'h05C, "R7 words held", {q_w, i_w}, {10'h05C, 10'h1E3});

    // R3 delivery in test and modulator modes
    mode = 2'b10;
    send_frame(10'h2A5, 10'h15A);
    mode = 2'b00;
    send_frame(10'h0C3, 10'h33C);
    chk(i_w == 10'h0C3 && q_w == 10'h33C, "R3 words together", {q_w, i_w}, {10'h33C, 10'h0C3});

    pad(4);
    chk(exp_q.size() == 0, "R3 all expected updates seen", exp_q.size(), 0);
    finish_run();
  end
endmodule